// File: doc/BRIEF.md
# Byte-Lane Aware System Register File

This block holds five word-wide system registers on a 16-bit bus that carries both full-word and single-byte writes. Bits 4:1 of the byte address pick the register, and bit 0 says whether a byte cycle targets the odd (high) or the even (low) byte. In a byte cycle the write data always arrives in the low eight bits of the data bus. Each register has its own rule for the lane that a byte write reaches.

There are five registers. The interrupt-request register and the stack-limit register accept a high byte only. The memory-error register collects error flags from hardware and software clears them by writing ones. The configuration/display register accepts the low byte only. The scratch register merges the addressed byte into the byte it already holds. Reads are combinational and return the stored value of the addressed register.

Top module: `sysreg_file`

## Requirements
- R1: The register index is `addr[4:1]` and the odd-byte flag is `addr[0]`. The indices are 0xD for the interrupt-request register, 0xE for stack-limit, 0x2 for memory-error, 0x4 for configuration/display and 0x6 for scratch. `rdata` returns the addressed register in the same cycle and returns 0 for any other index.
- R2: A byte write to the even address of the interrupt-request or stack-limit register leaves that register unchanged.
- R3: A byte write to the odd address of the interrupt-request or stack-limit register stores `wdata[7:0]` in bits 15:8 and zero in bits 7:0, after the writable mask is applied.
- R4: A word write (`byte_wr`=0) loads `wdata` ANDed with the register's writable mask. The masks are 0xFE00 for interrupt-request, 0xFF00 for stack-limit, 0xFFFF for memory-error, 0x00FF for configuration/display and 0xFFFF for scratch. No register ever holds a bit outside its mask.
- R5: The memory-error register clears every bit written as one. A word write uses `wdata`, an odd-byte write uses `wdata[7:0]` shifted to bits 15:8, and an even-byte write uses `wdata[7:0]` in bits 7:0. Bits set in `mem_err_set` are ORed in on the same edge and take priority over a clear. With no write and no set, no bit rises.
- R6: A byte write to the odd address of the configuration/display register is ignored. An even-byte write loads `{8'h00, wdata[7:0]}` masked.
- R7: A byte write to the scratch register replaces only the addressed byte and keeps the other byte.
- R8: After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| byte_wr | input | 1 | 1 = byte cycle, 0 = word cycle |
| addr | input | 5 | Byte address; bits 4:1 pick the register, bit 0 is the odd-byte flag |
| wdata | input | 16 | Write data; for a byte cycle the byte is in bits 7:0 |
| mem_err_set | input | 16 | Hardware error flags to set in the memory-error register |
| rdata | output | 16 | Read data of the addressed register |

## Verification
Each write rule is tried with a word write, an even-byte write and an odd-byte write. The data carries junk in its upper byte, so a design that takes the byte lane from the wrong half of the bus reads back a different value. The even-byte writes tell apart a register that ignores them from one that merges them or zero-extends them. The odd-byte writes show whether the byte was shifted up and whether the low byte was zeroed or kept. The memory-error tests use patterns that differ between the two lanes, along with a set that coincides with a clear, so lane-shift and priority faults are visible.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
   localparam int RULE_SHIFT_HI = 0;
   localparam int RULE_W1C      = 1;
   localparam int RULE_LOW_ONLY = 2;
   localparam int RULE_MERGE    = 3;

   localparam int N_SYSREG = 5;
   localparam int IDX_IRQ  = 0;
   localparam int IDX_STK  = 1;
   localparam int IDX_MERR = 2;
   localparam int IDX_CFG  = 3;
   localparam int IDX_SCR  = 4;

   function automatic int rule_of(input int idx);
      case (idx)
         IDX_IRQ, IDX_STK: rule_of = RULE_SHIFT_HI;
         IDX_MERR:         rule_of = RULE_W1C;
         IDX_CFG:          rule_of = RULE_LOW_ONLY;
         default:          rule_of = RULE_MERGE;
      endcase
   endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode #(
   parameter int AW   = 5,
   parameter int NREG = 5,
   parameter logic [NREG*(AW-1)-1:0] IDXS = '0
) (
   input  logic [AW-1:0]   addr,
   output logic [NREG-1:0] sel,
   output logic            odd
);
   localparam int FW = AW - 1;

   if (AW < 2) begin : g_bad_aw
      $error("sysreg_decode: AW must be at least 2");
   end

   assign odd = addr[0];

   for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign sel[i] = (addr[AW-1:1] == IDXS[i*FW +: FW]);
      for (genvar j = i + 1; j < NREG; j++) begin : g_uniq
         if (IDXS[i*FW +: FW] == IDXS[j*FW +: FW]) begin : g_dup
            $error("sysreg_decode: duplicate register index");
         end
      end
   end
endmodule

// File: rtl/sysreg_cell.sv
module sysreg_cell #(
   parameter int          W    = 16,
   parameter int          RULE = 0,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic         byte_wr,
   input  logic         odd,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   import sysreg_pkg::*;
   localparam int HB = W / 2;

   if ((W % 2) != 0) begin : g_bad_w
      $error("sysreg_cell: W must be even");
   end

   if (RULE == RULE_SHIFT_HI) begin : g_shift
      logic [W-1:0] up_lane;
      logic         unused_set;
      assign up_lane    = {wdata[HB-1:0], {HB{1'b0}}};
      assign unused_set = ^hw_set;
      always_ff @(posedge clk) begin
         if (!rst_n)           q <= '0;
         else if (wr) begin
            if (!byte_wr)      q <= wdata & MASK;
            else if (odd)      q <= up_lane & MASK;
         end
      end
   end else if (RULE == RULE_W1C) begin : g_w1c
      logic [W-1:0] clr;
      always_comb begin
         if (!wr)              clr = '0;
         else if (!byte_wr)    clr = wdata;
         else if (odd)         clr = {wdata[HB-1:0], {HB{1'b0}}};
         else                  clr = {{HB{1'b0}}, wdata[HB-1:0]};
      end
      always_ff @(posedge clk) begin
         if (!rst_n)           q <= '0;
         else                  q <= ((q & ~clr) | hw_set) & MASK;
      end
   end else if (RULE == RULE_LOW_ONLY) begin : g_low
      logic [W-1:0] lo_lane;
      logic         unused_set;
      assign lo_lane    = {{HB{1'b0}}, wdata[HB-1:0]};
      assign unused_set = ^hw_set;
      always_ff @(posedge clk) begin
         if (!rst_n)           q <= '0;
         else if (wr) begin
            if (!byte_wr)      q <= wdata & MASK;
            else if (!odd)     q <= lo_lane & MASK;
         end
      end
   end else begin : g_merge
      logic unused_set;
      assign unused_set = ^hw_set;
      always_ff @(posedge clk) begin
         if (!rst_n)           q <= '0;
         else if (wr) begin
            if (!byte_wr)      q <= wdata & MASK;
            else if (odd)      q <= {wdata[HB-1:0], q[HB-1:0]} & MASK;
            else               q <= {q[W-1:HB], wdata[HB-1:0]} & MASK;
         end
      end
   end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file #(
   parameter int          DW        = 16,
   parameter int          AW        = 5,
   parameter logic [3:0]  IRQ_IDX   = 4'hD,
   parameter logic [3:0]  STK_IDX   = 4'hE,
   parameter logic [3:0]  MERR_IDX  = 4'h2,
   parameter logic [3:0]  CFG_IDX   = 4'h4,
   parameter logic [3:0]  SCR_IDX   = 4'h6,
   parameter logic [15:0] IRQ_MASK  = 16'hFE00,
   parameter logic [15:0] STK_MASK  = 16'hFF00,
   parameter logic [15:0] MERR_MASK = 16'hFFFF,
   parameter logic [15:0] CFG_MASK  = 16'h00FF,
   parameter logic [15:0] SCR_MASK  = 16'hFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          byte_wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] mem_err_set,
   output logic [DW-1:0] rdata
);
   import sysreg_pkg::*;
   localparam int NREG = N_SYSREG;
   localparam int FW   = AW - 1;
   localparam logic [NREG*FW-1:0] IDXS =
      {FW'(SCR_IDX), FW'(CFG_IDX), FW'(MERR_IDX), FW'(STK_IDX), FW'(IRQ_IDX)};
   localparam logic [NREG*DW-1:0] MASKS =
      {DW'(SCR_MASK), DW'(CFG_MASK), DW'(MERR_MASK), DW'(STK_MASK), DW'(IRQ_MASK)};

   if (DW != 16) begin : g_bad_dw
      $error("sysreg_file: DW must be 16");
   end
   if (AW != 5) begin : g_bad_aw
      $error("sysreg_file: AW must be 5");
   end

   logic [NREG-1:0]    sel;
   logic               odd;
   logic [NREG*DW-1:0] reg_flat;

   sysreg_decode #(.AW(AW), .NREG(NREG), .IDXS(IDXS)) u_dec (
      .addr (addr),
      .sel  (sel),
      .odd  (odd)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] set_in;
      if (rule_of(i) == RULE_W1C) begin : g_set
         assign set_in = mem_err_set;
      end else begin : g_noset
         assign set_in = '0;
      end
      sysreg_cell #(.W(DW), .RULE(rule_of(i)), .MASK(MASKS[i*DW +: DW])) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (wr_en & sel[i]),
         .byte_wr (byte_wr),
         .odd     (odd),
         .wdata   (wdata),
         .hw_set  (set_in),
         .q       (reg_flat[i*DW +: DW])
      );
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (sel[i]) rdata = rdata | reg_flat[i*DW +: DW];
      end
   end
endmodule

// File: rtl/sysreg_file_chk.sv
module sysreg_file_chk #(
   parameter logic [3:0]  IRQ_IDX  = 4'hD,
   parameter logic [3:0]  STK_IDX  = 4'hE,
   parameter logic [3:0]  MERR_IDX = 4'h2,
   parameter logic [3:0]  CFG_IDX  = 4'h4,
   parameter logic [3:0]  SCR_IDX  = 4'h6,
   parameter logic [15:0] STK_MASK = 16'hFF00
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        byte_wr,
   input logic [4:0]  addr,
   input logic [15:0] wdata,
   input logic [15:0] mem_err_set,
   input logic [79:0] reg_flat
);
   logic [15:0] irq_q, stk_q, merr_q, cfg_q, scr_q;
   assign irq_q  = reg_flat[15:0];
   assign stk_q  = reg_flat[31:16];
   assign merr_q = reg_flat[47:32];
   assign cfg_q  = reg_flat[63:48];
   assign scr_q  = reg_flat[79:64];

   logic byte_even, byte_odd;
   assign byte_even = wr_en && byte_wr && !addr[0];
   assign byte_odd  = wr_en && byte_wr && addr[0];

   assert_even_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_even && addr[4:1] == IRQ_IDX) |=> $stable(irq_q));

   assert_odd_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_odd && addr[4:1] == STK_IDX) |=> stk_q == ({$past(wdata[7:0]), 8'h00} & STK_MASK));

   assert_mask_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_q & ~STK_MASK) == 16'h0000);

   assert_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && mem_err_set == 16'h0000) |=> (merr_q & ~$past(merr_q)) == 16'h0000);

   assert_set_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_err_set != 16'h0000) |=> (merr_q & $past(mem_err_set)) == $past(mem_err_set));

   assert_odd_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_odd && addr[4:1] == CFG_IDX) |=> $stable(cfg_q));

   assert_merge_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_odd && addr[4:1] == SCR_IDX) |=> scr_q[7:0] == $past(scr_q[7:0]));

   assert_reset_R8: assert property (@(posedge clk)
      !rst_n |=> (reg_flat == 80'h0));
endmodule

bind sysreg_file sysreg_file_chk #(
   .IRQ_IDX (IRQ_IDX),
   .STK_IDX (STK_IDX),
   .MERR_IDX(MERR_IDX),
   .CFG_IDX (CFG_IDX),
   .SCR_IDX (SCR_IDX),
   .STK_MASK(STK_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .byte_wr    (byte_wr),
   .addr       (addr),
   .wdata      (wdata),
   .mem_err_set(mem_err_set),
   .reg_flat   (reg_flat)
);

// File: tb/sysreg_file_bench.sv
`timescale 1ns/1ps
module sysreg_file_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        byte_wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] mem_err_set = '0;
   logic [15:0] rdata;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #4 clk = ~clk;

   sysreg_file u_sysreg_file (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_wr(byte_wr),
      .addr(addr), .wdata(wdata), .mem_err_set(mem_err_set), .rdata(rdata)
   );

   // Byte addresses: register index << 1, plus 1 for the odd byte.
   localparam logic [4:0] A_IRQ  = 5'h1A;
   localparam logic [4:0] A_STK  = 5'h1C;
   localparam logic [4:0] A_MERR = 5'h04;
   localparam logic [4:0] A_CFG  = 5'h08;
   localparam logic [4:0] A_SCR  = 5'h0C;

   task automatic wr(input logic [4:0] a, input logic [15:0] d,
                     input logic byt, input logic [15:0] set = 16'h0);
      @(posedge clk); #2;
      wr_en = 1'b1; byte_wr = byt; addr = a; wdata = d; mem_err_set = set;
   endtask

   task automatic pulse_set(input logic [15:0] set);
      @(posedge clk); #2;
      wr_en = 1'b0; mem_err_set = set;
   endtask

   task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
      item_t it;
      @(posedge clk); #2;
      wr_en = 1'b0; byte_wr = 1'b0; mem_err_set = '0; addr = a;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (rdata !== it.exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         failures++;
         $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R8 reset state
      rd(A_IRQ,  16'h0000, "R8 irq reset");
      rd(A_STK,  16'h0000, "R8 stk reset");
      rd(A_MERR, 16'h0000, "R8 merr reset");
      rd(A_CFG,  16'h0000, "R8 cfg reset");
      rd(A_SCR,  16'h0000, "R8 scr reset");
      // R4 word writes under each mask
      wr(A_IRQ, 16'hFFFF, 1'b0); rd(A_IRQ, 16'hFE00, "R4 irq word mask");
      wr(A_STK, 16'h1234, 1'b0); rd(A_STK, 16'h1200, "R4 stk word mask");
      wr(A_CFG, 16'hABCD, 1'b0); rd(A_CFG, 16'h00CD, "R4 cfg word mask");
      wr(A_SCR, 16'h5A5A, 1'b0); rd(A_SCR, 16'h5A5A, "R4 scr word");
      // R1 unmapped index and odd-address read
      rd(5'h00, 16'h0000, "R1 unmapped read");
      rd(A_STK | 5'h01, 16'h1200, "R1 odd address read");
      // R2 even byte ignored
      wr(A_IRQ, 16'hFF77, 1'b1); rd(A_IRQ, 16'hFE00, "R2 irq even ignored");
      wr(A_STK, 16'hEE55, 1'b1); rd(A_STK, 16'h1200, "R2 stk even ignored");
      // R3 odd byte shifted up, low zeroed
      wr(A_IRQ | 5'h01, 16'hFF81, 1'b1); rd(A_IRQ, 16'h8000, "R3 irq odd shift");
      wr(A_STK | 5'h01, 16'h003C, 1'b1); rd(A_STK, 16'h3C00, "R3 stk odd shift");
      // R6 configuration lanes
      wr(A_CFG | 5'h01, 16'h0011, 1'b1); rd(A_CFG, 16'h00CD, "R6 cfg odd ignored");
      wr(A_CFG, 16'hEE42, 1'b1);         rd(A_CFG, 16'h0042, "R6 cfg even load");
      // R7 merge
      wr(A_SCR | 5'h01, 16'h11A7, 1'b1); rd(A_SCR, 16'hA75A, "R7 scr odd merge");
      wr(A_SCR, 16'h223C, 1'b1);         rd(A_SCR, 16'hA73C, "R7 scr even merge");
      // R5 memory error set and write-one-to-clear per lane
      pulse_set(16'hFFFF);               rd(A_MERR, 16'hFFFF, "R5 merr set");
      wr(A_MERR, 16'h000F, 1'b0);        rd(A_MERR, 16'hFFF0, "R5 merr word clear");
      wr(A_MERR | 5'h01, 16'hFF81, 1'b1); rd(A_MERR, 16'h7EF0, "R5 merr odd clear");
      wr(A_MERR, 16'h0FF0, 1'b1);        rd(A_MERR, 16'h7E00, "R5 merr even clear");
      wr(A_MERR, 16'h0001, 1'b0, 16'h0001); rd(A_MERR, 16'h7E01, "R5 set beats clear");
      rd(A_MERR, 16'h7E01, "R5 merr idle holds");
      @(posedge clk); @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule